// File: doc/BRIEF.md
# Sliding-Window SHA-256 Message Schedule Generator

This block supplies the 64 message-schedule words that a SHA-256 compression round loop consumes for one 512-bit block. Only sixteen 32-bit registers hold the schedule. A load strobe copies the block into those registers. After that, each word request from the round engine returns one schedule word.

The first sixteen requests return the loaded words unchanged. Each later request computes a new word from the window, shifts the window down by one register, writes the new word into the top register, and presents the same word on the output. The expansion needs no 64-entry store and no write addressing.

The word output and its valid flag are registered. A word appears in the cycle after the request that produced it.

Top module: `wsched_top`

## Requirements
- R1: While reset is high, and in the cycle after it falls, `w_o` reads 0 and `w_valid_o` reads 0.
- R2: After a load, the first 16 accepted requests return block words 0 to 15 in that order. Word 0 is `blk_i[511:480]` and word k is `blk_i[511-32k -: 32]`.
- R3: Requests 17 to 64 after a load return W[t] for t = 16 to 63. Here W[t] = s1(W[t-2]) + W[t-7] + s0(W[t-15]) + W[t-16] mod 2^32, with s0(x) = ror7 ^ ror18 ^ shr3 and s1(x) = ror17 ^ ror19 ^ shr10.
- R4: A request with no load in the same cycle sets `w_valid_o` high for exactly the next cycle, and the word appears in that same cycle. When no request comes, `w_valid_o` is 0 and `w_o` keeps its value.
- R5: Once 64 words have been returned, further requests are ignored: `w_valid_o` stays 0 and `w_o` keeps the last word.
- R6: A load in the middle of a schedule restarts it. The next request returns word 0 of the newly loaded block.
- R7: A load takes priority over a request in the same cycle. No word is produced, and in the following cycle `w_o` is 0 and `w_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load the block and restart the schedule |
| blk_i | input | 512 | Message block; word 0 in the top bits |
| req_i | input | 1 | Request the next schedule word |
| w_o | output | 32 | Current schedule word (registered) |
| w_valid_o | output | 1 | One-cycle pulse when `w_o` carries a new word |

## Verification
The bench aims at four corner cases:
- Round 16. This is the switch from direct words to computed ones. A design that shifts too early, or picks the wrong taps, returns an off-by-one word from there on.
- Words 0 and 63. A reversed word order in the block shows up on the very first word. An error in the sigma functions or the tap positions shows up in some word from 16 onward, across several all-zero, all-ones and mixed blocks.
- Requests after the 64th word. A design that keeps expanding would raise valid here, or change the word.
- Loads that cut into a running schedule, and a load and a request in the same cycle. A design that lets the request through would return block word 1 first, or pulse valid.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  localparam int WORD_W = 32;

  function automatic logic [WORD_W-1:0] rotr(input logic [WORD_W-1:0] x, input int n);
    rotr = (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic logic [WORD_W-1:0] small_s0(input logic [WORD_W-1:0] x);
    small_s0 = rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic logic [WORD_W-1:0] small_s1(input logic [WORD_W-1:0] x);
    small_s1 = rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction
endpackage

// File: rtl/wsched_window.sv
module wsched_window #(
  parameter int WORD   = 32,
  parameter int NWORDS = 16
) (
  input  logic                              clk,
  input  logic                              load_i,
  input  logic [NWORDS*WORD-1:0]            blk_i,
  input  logic                              shift_i,
  input  logic [WORD-1:0]                   top_i,
  output logic [NWORDS-1:0][WORD-1:0]       win_o
);
  logic [NWORDS-1:0][WORD-1:0] win_q;

  for (genvar g = 0; g < NWORDS; g++) begin : g_slot
    logic [WORD-1:0] upper;
    if (g == NWORDS - 1) begin : g_top
      assign upper = top_i;
    end else begin : g_mid
      assign upper = win_q[g+1];
    end
    always_ff @(posedge clk) begin
      if (load_i)
        win_q[g] <= blk_i[(NWORDS-1-g)*WORD +: WORD];
      else if (shift_i)
        win_q[g] <= upper;
    end
  end

  assign win_o = win_q;

  // R3: a shift moves each slot one position down and puts the new word on top
  assert_shift_down_R3: assert property (@(posedge clk)
    (shift_i && !load_i) |=> (win_q[0] == $past(win_q[1])) && (win_q[NWORDS-1] == $past(top_i)));
  // R2: a load places block word 0 (the top bits) in the bottom slot
  assert_load_order_R2: assert property (@(posedge clk)
    load_i |=> win_q[0] == $past(blk_i[NWORDS*WORD-1 -: WORD]));
endmodule

// File: rtl/wsched_expand.sv
module wsched_expand
  import wsched_pkg::*;
#(
  parameter int NWORDS = 16
) (
  input  logic [NWORDS-1:0][WORD_W-1:0] win_i,
  output logic [WORD_W-1:0]             next_o
);
  localparam int TAP_S1 = NWORDS - 2;
  localparam int TAP_MID = NWORDS - 7;
  localparam int TAP_S0 = 1;
  localparam int TAP_OLD = 0;

  always_comb begin
    next_o = small_s1(win_i[TAP_S1]) + win_i[TAP_MID] + small_s0(win_i[TAP_S0]) + win_i[TAP_OLD];
  end
endmodule

// File: rtl/wsched_ctrl.sv
module wsched_ctrl #(
  parameter int NWORDS = 16,
  parameter int ROUNDS = 64,
  localparam int CW = $clog2(ROUNDS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          req_i,
  output logic          adv_o,
  output logic          direct_o,
  output logic [CW-1:0] rnd_o,
  output logic          valid_o
);
  logic [CW-1:0] rnd_q;
  logic          valid_q;

  assign adv_o    = req_i && !load_i && (rnd_q < CW'(ROUNDS));
  assign direct_o = rnd_q < CW'(NWORDS);
  assign rnd_o    = rnd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rnd_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= adv_o;
      if (load_i)
        rnd_q <= '0;
      else if (adv_o)
        rnd_q <= rnd_q + 1'b1;
    end
  end

  assign valid_o = valid_q;

  // R5: the round counter never passes the schedule length
  assert_round_bound_R5: assert property (@(posedge clk) disable iff (rst)
    rnd_q <= CW'(ROUNDS));
  // R5: with the schedule exhausted, a request gives no valid pulse
  assert_no_extra_R5: assert property (@(posedge clk) disable iff (rst)
    (rnd_q == CW'(ROUNDS) && !load_i) |=> !valid_q);
  // R7: a load suppresses any word in the following cycle
  assert_load_priority_R7: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (!valid_q && rnd_q == '0));
  // R4: a valid pulse lasts one cycle unless another request was accepted
  assert_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !adv_o) |=> !valid_q);
endmodule

// File: rtl/wsched_top.sv
module wsched_top
  import wsched_pkg::*;
#(
  parameter int NWORDS = 16,
  parameter int ROUNDS = 64,
  localparam int BLK_W = NWORDS * WORD_W,
  localparam int CW = $clog2(ROUNDS + 1),
  localparam int IW = $clog2(NWORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [BLK_W-1:0]   blk_i,
  input  logic               req_i,
  output logic [WORD_W-1:0]  w_o,
  output logic               w_valid_o
);
  logic                             adv, direct, shift;
  logic [CW-1:0]                    rnd;
  logic [NWORDS-1:0][WORD_W-1:0]    win;
  logic [WORD_W-1:0]                fresh;
  logic [WORD_W-1:0]                w_q;

  wsched_ctrl #(.NWORDS(NWORDS), .ROUNDS(ROUNDS)) u_ctrl (
    .clk(clk), .rst(rst), .load_i(load_i), .req_i(req_i),
    .adv_o(adv), .direct_o(direct), .rnd_o(rnd), .valid_o(w_valid_o)
  );

  wsched_expand #(.NWORDS(NWORDS)) u_expand (
    .win_i(win), .next_o(fresh)
  );

  assign shift = adv && !direct;

  wsched_window #(.WORD(WORD_W), .NWORDS(NWORDS)) u_window (
    .clk(clk), .load_i(load_i), .blk_i(blk_i), .shift_i(shift),
    .top_i(fresh), .win_o(win)
  );

  always_ff @(posedge clk) begin
    if (rst || load_i)
      w_q <= '0;
    else if (adv)
      w_q <= direct ? win[rnd[IW-1:0]] : fresh;
  end

  assign w_o = w_q;

  // R1: the first cycle after reset shows a cleared output
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (w_o == '0 && !w_valid_o));
  // R4: without a request or load the word holds
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!req_i && !load_i) |=> ($stable(w_o) && !w_valid_o));
  // R3: a computed word lands on the output and in the top slot together
  assert_same_step_R3: assert property (@(posedge clk) disable iff (rst)
    shift |=> w_o == win[NWORDS-1]);
endmodule

// File: tb/wsched_top_tb.sv
`timescale 1ns/1ps
module wsched_top_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load_i = 1'b0;
  logic [511:0] blk_i = '0;
  logic         req_i = 1'b0;
  logic [31:0]  w_o;
  logic         w_valid_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_w [64];

  always #2.5 clk = ~clk;

  wsched_top u_dut (
    .clk(clk), .rst(rst), .load_i(load_i), .blk_i(blk_i),
    .req_i(req_i), .w_o(w_o), .w_valid_o(w_valid_o)
  );

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  task automatic build_exp(input logic [511:0] b);
    for (int t = 0; t < 64; t++) begin
      if (t < 16) exp_w[t] = b[511 - 32*t -: 32];
      else exp_w[t] = (rr(exp_w[t-2], 17) ^ rr(exp_w[t-2], 19) ^ (exp_w[t-2] >> 10))
                    + exp_w[t-7]
                    + (rr(exp_w[t-15], 7) ^ rr(exp_w[t-15], 18) ^ (exp_w[t-15] >> 3))
                    + exp_w[t-16];
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [511:0] b);
    @(negedge clk); load_i = 1'b1; blk_i = b;
    @(negedge clk); load_i = 1'b0;
    build_exp(b);
  endtask

  task automatic do_req();
    @(negedge clk); req_i = 1'b1;
    @(negedge clk); req_i = 1'b0;
  endtask

  task automatic run_block(input logic [511:0] b, input int gap);
    logic [31:0] last;
    do_load(b);
    check("R7 valid after load", {31'b0, w_valid_o}, 32'd0);
    for (int t = 0; t < 64; t++) begin
      do_req();
      check("R4 valid pulse", {31'b0, w_valid_o}, 32'd1);
      check(t < 16 ? "R2 direct word" : "R3 expanded word", w_o, exp_w[t]);
      last = w_o;
      for (int g = 0; g < (t % gap); g++) begin
        @(negedge clk);
        check("R4 idle valid", {31'b0, w_valid_o}, 32'd0);
        check("R4 idle hold", w_o, last);
      end
    end
    for (int k = 0; k < 2; k++) begin
      do_req();
      check("R5 valid after 64", {31'b0, w_valid_o}, 32'd0);
      check("R5 word after 64", w_o, exp_w[63]);
    end
  endtask

  function automatic logic [511:0] mix_block(input logic [31:0] seed);
    logic [511:0] b;
    logic [31:0] s;
    s = seed;
    for (int i = 0; i < 16; i++) begin
      s = s * 32'h9E3779B1 + 32'h7F4A7C15 + i;
      b[511 - 32*i -: 32] = s ^ (s >> 13);
    end
    return b;
  endfunction

  initial begin
    logic [511:0] abc;
    abc = '0;
    abc[511:480] = 32'h61626380;
    abc[31:0] = 32'h00000018;

    repeat (3) @(negedge clk);
    check("R1 reset word", w_o, 32'd0);
    check("R1 reset valid", {31'b0, w_valid_o}, 32'd0);
    @(negedge clk); rst = 1'b0;
    check("R1 after reset word", w_o, 32'd0);
    check("R1 after reset valid", {31'b0, w_valid_o}, 32'd0);

    run_block(abc, 1);
    run_block('0, 2);
    run_block({512{1'b1}}, 3);
    for (int s = 1; s <= 4; s++) run_block(mix_block(32'(s * 977)), s + 1);

    // R6: restart in the middle of a schedule
    do_load(mix_block(32'h1234));
    for (int t = 0; t < 20; t++) do_req();
    check("R6 before restart", w_o, exp_w[19]);
    do_load(abc);
    do_req();
    check("R6 restart word0", w_o, exp_w[0]);
    do_req();
    check("R6 restart word1", w_o, exp_w[1]);

    // R7: load and request in the same cycle
    @(negedge clk); load_i = 1'b1; req_i = 1'b1; blk_i = mix_block(32'h55);
    @(negedge clk); load_i = 1'b0; req_i = 1'b0;
    build_exp(mix_block(32'h55));
    check("R7 word cleared", w_o, 32'd0);
    check("R7 no valid", {31'b0, w_valid_o}, 32'd0);
    do_req();
    check("R7 first word", w_o, exp_w[0]);
    check("R7 first valid", {31'b0, w_valid_o}, 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule